// File: doc/BRIEF.md
# PCI Interrupt Level Steering Router

The router takes eight level-sensitive PCI interrupt requests (lines A through H) and one power-management system control interrupt (SCI) level. From them it produces the input levels for two interrupt controllers: a 16-input legacy controller and a 24-input APIC. Each PCI request line has an 8-bit steering byte. The byte names the legacy IRQ the line lands on and has a flag that detaches the line from the legacy side. Several enabled lines may name the same IRQ, and that legacy input then carries the OR of their levels. On the APIC side no routing takes place: line n always drives global input 16 + n.

A 3-bit SCI select code places the SCI on one of five IRQ numbers. Three of them are below 16, so the SCI reaches both controllers. Two are above 16, so it reaches only the APIC. The remaining codes leave the SCI unconnected. Configuration arrives through a plain address/data/write-enable port. All request inputs are sampled once, and both output vectors are derived combinationally from the registered state. A write or an input change therefore shows at the outputs after one clock edge.

Top module: `irq_steer_router`

## Requirements
- R1: After a synchronous active-low reset, every steering byte holds 0x80 (detached), the SCI select code is 0, the stored SCI level is 0, and with all request inputs low every output is low.
- R2: A write at address 0..3 loads the steering byte of lines A..D, at 8..11 lines E..H, and at 12 the SCI select code (data bits 2:0). Writes to any other address change nothing.
- R3: Steering byte bits 3:0 give the legacy IRQ number and bit 7 set detaches the line, so it drives no legacy input.
- R4: Legacy output k is the OR of the levels of all attached lines whose IRQ field equals k. Lines sharing k are wired together.
- R5: APIC output 16 + n equals the level of request line n, independent of its steering byte.
- R6: SCI select code 0, 1, 2, 4, 5 places the SCI on IRQ 9, 10, 11, 20, 21 respectively. Codes 3, 6 and 7 route it nowhere.
- R7: An SCI placed on IRQ 9, 10 or 11 is ORed into both legacy output k and APIC output k. One placed on 20 or 21 is ORed into the APIC output only.
- R8: Request and SCI inputs are registered once. A change or a configuration write becomes visible at the outputs after the next rising clock edge and not before.
- R9: Steering byte bits 6:4 have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write enable |
| cfg_addr | input | 4 | Configuration register address |
| cfg_wdata | input | 8 | Configuration write data |
| pirq_in | input | 8 | PCI request levels, bit n = line n (A = 0) |
| sci_in | input | 1 | SCI level |
| leg_irq | output | 16 | Legacy controller input levels |
| apic_irq | output | 24 | APIC input levels |

## Verification
The hardest case to reach is several attached lines steered onto the same legacy IRQ. In that case the output must follow the OR of an arbitrary subset of active lines. The bench steers all eight lines to one IRQ and sweeps all 256 level patterns. It also walks every line across all 16 IRQ numbers, and steps the SCI through all eight select codes. Finally, it runs a deterministic mix of steering bytes, including bytes with the unused bits set.

// File: rtl/irq_steer_pkg.sv
// Shared types and decode helpers for the interrupt steering router.
// Assumes legacy IRQ numbers fit in four bits and APIC indices in five.
package irq_steer_pkg;

    typedef struct packed {
        logic       detach;
        logic [2:0] unused;
        logic [3:0] irq;
    } steer_t;

    localparam logic [7:0] STEER_RESET = 8'h80;
    localparam logic [2:0] SCI_RESET   = 3'd0;

    typedef struct packed {
        logic       valid;
        logic [4:0] irq;
    } sci_dest_t;

    // Turn an SCI select code into a destination IRQ (valid=0 for reserved).
    function automatic sci_dest_t sci_decode(input logic [2:0] code);
        sci_dest_t d;
        d.valid = 1'b1;
        unique case (code)
            3'd0:    d.irq = 5'd9;
            3'd1:    d.irq = 5'd10;
            3'd2:    d.irq = 5'd11;
            3'd4:    d.irq = 5'd20;
            3'd5:    d.irq = 5'd21;
            default: begin
                d.irq   = 5'd0;
                d.valid = 1'b0;
            end
        endcase
        return d;
    endfunction

endpackage

// File: rtl/steer_regs.sv
// Configuration register file: one steering byte per request line plus the
// SCI select code. Lower half of the lines sits at LO_BASE, upper half at
// HI_BASE, SCI select at SCI_ADDR. Unmapped writes are dropped.
module steer_regs
    import irq_steer_pkg::*;
#(
    parameter int NUM_PIRQ = 8,
    parameter int ADDR_W   = 4,
    parameter int LO_BASE  = 0,
    parameter int HI_BASE  = 8,
    parameter int SCI_ADDR = 12
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cfg_we,
    input  logic [ADDR_W-1:0]        cfg_addr,
    input  logic [7:0]               cfg_wdata,
    output logic [NUM_PIRQ-1:0][7:0] steer_q,
    output logic [2:0]               sci_code_q
);
    localparam int HALF = NUM_PIRQ / 2;

    for (genvar n = 0; n < NUM_PIRQ; n++) begin : g_line
        localparam int MY_ADDR = (n < HALF) ? (LO_BASE + n) : (HI_BASE + n - HALF);

        // Holds the steering byte of line n.
        always_ff @(posedge clk) begin
            if (!rst_n)
                steer_q[n] <= STEER_RESET;
            else if (cfg_we && (cfg_addr == ADDR_W'(MY_ADDR)))
                steer_q[n] <= cfg_wdata;
        end

        assert_write_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_we && cfg_addr == ADDR_W'(MY_ADDR)) |=> steer_q[n] == $past(cfg_wdata));

        assert_reset_default_R1: assert property (@(posedge clk) disable iff (!rst_n)
            !$past(rst_n) |-> (steer_q[n] == STEER_RESET && sci_code_q == SCI_RESET));
    end

    // Holds the SCI select code.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sci_code_q <= SCI_RESET;
        else if (cfg_we && (cfg_addr == ADDR_W'(SCI_ADDR)))
            sci_code_q <= cfg_wdata[2:0];
    end

endmodule

// File: rtl/level_sampler.sv
// Registers the request and SCI levels once so that outputs depend only on
// state. SCI is already a single bit; its stored copy clears on reset.
module level_sampler #(
    parameter int NUM_PIRQ = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PIRQ-1:0] pirq_in,
    input  logic                sci_in,
    output logic [NUM_PIRQ-1:0] pirq_q,
    output logic                sci_q
);
    // Captures the input levels every cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pirq_q <= '0;
            sci_q  <= 1'b0;
        end else begin
            pirq_q <= pirq_in;
            sci_q  <= sci_in;
        end
    end

    assert_sample_delay_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (sci_q == $past(sci_in) && pirq_q == $past(pirq_in)));

endmodule

// File: rtl/level_combiner.sv
// Builds both controller input vectors from registered state: legacy side
// as wired-OR of attached lines per IRQ, APIC side as fixed offset map, and
// the SCI ORed onto whichever index its select code names.
module level_combiner
    import irq_steer_pkg::*;
#(
    parameter int NUM_PIRQ = 8,
    parameter int NUM_LEG  = 16,
    parameter int NUM_GSI  = NUM_LEG + NUM_PIRQ
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_PIRQ-1:0][7:0] steer_q,
    input  logic [2:0]               sci_code_q,
    input  logic [NUM_PIRQ-1:0]      pirq_q,
    input  logic                     sci_q,
    output logic [NUM_LEG-1:0]       leg_irq,
    output logic [NUM_GSI-1:0]       apic_irq
);
    sci_dest_t dest;
    logic      any_attached;

    // Decodes where the SCI goes.
    always_comb dest = sci_decode(sci_code_q);

    // ORs every contributor into its legacy and APIC positions.
    always_comb begin
        steer_t s;
        leg_irq      = '0;
        apic_irq     = '0;
        any_attached = 1'b0;
        for (int n = 0; n < NUM_PIRQ; n++) begin
            s = steer_t'(steer_q[n]);
            if (!s.detach) any_attached = 1'b1;
            if (pirq_q[n] && !s.detach && (32'(s.irq) < NUM_LEG))
                leg_irq[s.irq] = 1'b1;
            apic_irq[NUM_LEG + n] = pirq_q[n];
        end
        if (sci_q && dest.valid) begin
            apic_irq[dest.irq] = 1'b1;
            if (32'(dest.irq) < NUM_LEG)
                leg_irq[dest.irq[3:0]] = 1'b1;
        end
    end

    for (genvar n = 0; n < NUM_PIRQ; n++) begin : g_chk
        assert_apic_follows_R5: assert property (@(posedge clk) disable iff (!rst_n)
            pirq_q[n] |-> apic_irq[NUM_LEG + n]);
    end

    assert_sci_reaches_apic_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (sci_q && dest.valid) |-> apic_irq[dest.irq]);

    assert_quiet_legacy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!any_attached && !(sci_q && dest.valid)) |-> leg_irq == '0);

endmodule

// File: rtl/irq_steer_router.sv
// Top of the interrupt steering router: configuration registers, input
// sampling and level combining. Outputs follow state after one edge.
module irq_steer_router #(
    parameter int NUM_PIRQ = 8,
    parameter int NUM_LEG  = 16,
    parameter int ADDR_W   = 4,
    parameter int NUM_GSI  = NUM_LEG + NUM_PIRQ
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_we,
    input  logic [ADDR_W-1:0]   cfg_addr,
    input  logic [7:0]          cfg_wdata,
    input  logic [NUM_PIRQ-1:0] pirq_in,
    input  logic                sci_in,
    output logic [NUM_LEG-1:0]  leg_irq,
    output logic [NUM_GSI-1:0]  apic_irq
);
    logic [NUM_PIRQ-1:0][7:0] steer_q;
    logic [2:0]               sci_code_q;
    logic [NUM_PIRQ-1:0]      pirq_q;
    logic                     sci_q;

    steer_regs #(.NUM_PIRQ(NUM_PIRQ), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .steer_q(steer_q), .sci_code_q(sci_code_q)
    );

    level_sampler #(.NUM_PIRQ(NUM_PIRQ)) u_samp (
        .clk(clk), .rst_n(rst_n), .pirq_in(pirq_in), .sci_in(sci_in),
        .pirq_q(pirq_q), .sci_q(sci_q)
    );

    level_combiner #(.NUM_PIRQ(NUM_PIRQ), .NUM_LEG(NUM_LEG), .NUM_GSI(NUM_GSI)) u_comb (
        .clk(clk), .rst_n(rst_n), .steer_q(steer_q), .sci_code_q(sci_code_q),
        .pirq_q(pirq_q), .sci_q(sci_q), .leg_irq(leg_irq), .apic_irq(apic_irq)
    );

endmodule

// File: tb/irq_steer_router_tb.sv
module irq_steer_router_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_addr = '0;
    logic [7:0]  cfg_wdata = '0;
    logic [7:0]  pirq_in = '0;
    logic        sci_in = 1'b0;
    logic [15:0] leg_irq;
    logic [23:0] apic_irq;

    int n_checks = 0;
    int n_fail   = 0;

    // Bench model of the configuration state
    logic [7:0] m_steer [8];
    logic [2:0] m_code;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_steer_router u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .pirq_in(pirq_in), .sci_in(sci_in),
        .leg_irq(leg_irq), .apic_irq(apic_irq)
    );

    function automatic int sci_dest(input logic [2:0] c);
        case (c)
            3'd0: return 9;
            3'd1: return 10;
            3'd2: return 11;
            3'd4: return 20;
            3'd5: return 21;
            default: return -1;
        endcase
    endfunction

    task automatic expect_vecs(input logic [7:0] p, input logic s,
                               output logic [15:0] el, output logic [23:0] ea);
        int d;
        el = '0;
        ea = '0;
        for (int n = 0; n < 8; n++) begin
            if (p[n] && !m_steer[n][7]) el[m_steer[n][3:0]] = 1'b1;
            ea[16 + n] = p[n];
        end
        d = sci_dest(m_code);
        if (s && d >= 0) begin
            ea[d] = 1'b1;
            if (d < 16) el[d] = 1'b1;
        end
    endtask

    task automatic check(input string req, input logic [7:0] p, input logic s);
        logic [15:0] el;
        logic [23:0] ea;
        expect_vecs(p, s, el, ea);
        n_checks++;
        if (leg_irq !== el || apic_irq !== ea) begin
            n_fail++;
            $display("FAIL %s: leg=%h apic=%h expected leg=%h apic=%h",
                     req, leg_irq, apic_irq, el, ea);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        cfg_we    = 1'b1;
        cfg_addr  = a;
        cfg_wdata = d;
        step();
        cfg_we = 1'b0;
        if (a < 4)                 m_steer[a] = d;
        else if (a >= 8 && a < 12) m_steer[a - 4] = d;
        else if (a == 12)          m_code = d[2:0];
    endtask

    task automatic apply(input logic [7:0] p, input logic s);
        pirq_in = p;
        sci_in  = s;
        step();
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        for (int n = 0; n < 8; n++) m_steer[n] = 8'h80;
        m_code = 3'd0;
        @(negedge clk);
        step(); step(); step();
        rst_n = 1'b1;
        step();
        check("R1 reset state", 8'h00, 1'b0);

        // R1/R3/R5: detached lines reach only the APIC
        for (int n = 0; n < 8; n++) begin
            apply(8'(1 << n), 1'b0);
            check("R5 apic offset map, R3 detached", 8'(1 << n), 1'b0);
        end

        // R3/R4: each line across every IRQ number, mapped by address (R2)
        for (int n = 0; n < 8; n++) begin
            for (int k = 0; k < 16; k++) begin
                wr((n < 4) ? 4'(n) : 4'(n + 4), 8'(k));
                apply(8'(1 << n), 1'b0);
                check("R3 steering field / R2 address map", 8'(1 << n), 1'b0);
            end
            wr((n < 4) ? 4'(n) : 4'(n + 4), 8'h80);
            apply(8'(1 << n), 1'b0);
            check("R3 detach flag", 8'(1 << n), 1'b0);
        end

        // R4: all lines sharing IRQ 5, every level pattern
        for (int n = 0; n < 8; n++) wr((n < 4) ? 4'(n) : 4'(n + 4), 8'h05);
        for (int p = 0; p < 256; p++) begin
            apply(8'(p), 1'b0);
            check("R4 wired-OR sharing", 8'(p), 1'b0);
        end

        // R2: unmapped addresses ignored
        apply(8'hFF, 1'b0);
        for (int a = 4; a < 8; a++) begin
            wr(4'(a), 8'h03);
            check("R2 unmapped write ignored", 8'hFF, 1'b0);
        end
        for (int a = 13; a < 16; a++) begin
            wr(4'(a), 8'h0E);
            check("R2 unmapped write ignored", 8'hFF, 1'b0);
        end

        // R9: unused bits have no effect
        for (int n = 0; n < 8; n++) begin
            wr((n < 4) ? 4'(n) : 4'(n + 4), 8'h70 | 8'(n + 2));
            apply(8'(1 << n), 1'b0);
            check("R9 unused bits", 8'(1 << n), 1'b0);
        end

        // R6/R7: every SCI select code, SCI high and low
        for (int n = 0; n < 8; n++) wr((n < 4) ? 4'(n) : 4'(n + 4), 8'h80);
        for (int c = 0; c < 8; c++) begin
            wr(4'd12, 8'(c));
            apply(8'h00, 1'b1);
            check("R6 SCI select decode / R7 dual delivery", 8'h00, 1'b1);
            apply(8'h00, 1'b0);
            check("R6 SCI released", 8'h00, 1'b0);
        end

        // R8: latency of one edge
        wr(4'd0, 8'h07);
        wr(4'd12, 8'd1);
        pirq_in = 8'h01;
        sci_in  = 1'b1;
        #1;
        check("R8 no change before edge", 8'h00, 1'b0);
        step();
        check("R8 change after edge", 8'h01, 1'b1);
        wr(4'd0, 8'h0C);
        check("R8 write visible next edge", 8'h01, 1'b1);

        // Mixed deterministic configurations
        for (int i = 0; i < 200; i++) begin
            for (int n = 0; n < 8; n++)
                wr((n < 4) ? 4'(n) : 4'(n + 4), 8'((i * 37 + n * 53 + 11) & 8'h8F) | 8'((i & 7) << 4));
            wr(4'd12, 8'(i * 3));
            apply(8'((i * 29 + 7) & 8'hFF), 1'(i % 3 == 0));
            check("R4 R7 R9 mixed configuration", 8'((i * 29 + 7) & 8'hFF), 1'(i % 3 == 0));
        end

        // R1: reset clears everything again
        rst_n = 1'b0;
        pirq_in = 8'h00;
        sci_in = 1'b0;
        step(); step();
        rst_n = 1'b1;
        for (int n = 0; n < 8; n++) m_steer[n] = 8'h80;
        m_code = 3'd0;
        step();
        check("R1 reset after traffic", 8'h00, 1'b0);
        apply(8'h00, 1'b1);
        check("R1 SCI select back to default", 8'h00, 1'b1);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule